// File: doc/BRIEF.md
# Half-Rate Dual-Channel Output Sequencer

This block models the digital output timing of a two-channel pipelined converter. The converter runs from one clock at twice its sample rate. Two input words stand in for the two analog inputs. Both channels are sampled on the same clock edge, once every two clocks. Each sample is carried through a fixed pipeline of `LAT_CLK` clocks (12 by default) and then driven onto a registered output word.

A data-valid strobe toggles at half the clock rate. The output words change on the edge where the strobe falls, so a receiver can latch them on the following rising edge of the strobe.

An active-high reset gives a known phase between the clock, the sampling edge and the strobe. While reset is high, the strobe is cleared at once, with no wait for a clock edge. Reset is released synchronously. An `out_invalid` flag marks every output word that was produced before the first post-reset sample arrives.

The data path is a free-running stream with no ready input and no back-pressure. One word pair is produced per strobe period whether or not the receiver takes it. Words that the receiver misses are lost.

Top module: `halfrate_dual_seq`

## Requirements
- R1: While `rst` is high, `dvalid` is 0. The clear happens without waiting for a clock edge.
- R2: A clock edge that samples `rst` high leaves `chan_a_out` and `chan_b_out` unchanged.
- R3: Number the rising edges after `rst` is sampled low as E1, E2, and so on. After Ek, `dvalid` is 1 for even k and 0 for odd k. Its first rise is therefore at E2, and it toggles on every edge after that.
- R4: Both channel inputs are sampled together on the odd edges E1, E3, E5 and so on. Input values present at even edges never reach the outputs.
- R5: The sample taken at Ek appears on the outputs at E(k+`LAT_CLK`). With the default of 12, that is 6 strobe periods later.
- R6: The outputs change only on edges that leave `dvalid` at 0. They hold across the following rising edge of `dvalid`.
- R7: `out_invalid` is 1 after any edge that samples `rst` high. It stays 1 through E(`LAT_CLK`) and becomes 0 at E(`LAT_CLK`+1). It falls on an edge where `dvalid` falls.
- R8: Channel A and channel B travel in separate paths. `chan_a_out` carries only `chan_a_in` samples, and `chan_b_out` carries only `chan_b_in` samples.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock at twice the sample rate |
| rst | input | 1 | Active-high reset: clears the strobe at once, released synchronously |
| chan_a_in | input | WORD_W | Channel A input word |
| chan_b_in | input | WORD_W | Channel B input word |
| dvalid | output | 1 | Half-rate data-valid strobe; latch the outputs on its rising edge |
| chan_a_out | output | WORD_W | Channel A output word |
| chan_b_out | output | WORD_W | Channel B output word |
| out_invalid | output | 1 | High while the outputs carry pre-reset or latency-period data |

## Verification
The main function is driven with three input patterns:

- **Incrementing ramp.** This exposes a latency that is off by one strobe period, because each output then maps to a different ramp value.
- **Alternating all-ones and all-zeros words.** This catches bits that are stuck or swapped between the channels.
- **Walking one.** This shows which bit position, if any, is misrouted.

In every pattern, the words presented at even edges are a distinct junk value. A wrong sampling phase therefore shows up as junk on the outputs. A reset in mid-stream is applied while the strobe is high. It tells apart a clear that waits for the clock edge from an immediate one. It also shows whether the output words are held or overwritten while reset stays high.

// File: rtl/hrds_pkg.sv
`timescale 1ns/1ps
package hrds_pkg;
  // Two-state phase of the half-rate sample clock.
  typedef enum logic {
    PH_CAPTURE = 1'b0,  // this edge samples the inputs and advances the pipe
    PH_HOLD    = 1'b1   // this edge only raises the strobe
  } phase_t;
endpackage

// File: rtl/hrds_phase.sv
`timescale 1ns/1ps
module hrds_phase
  import hrds_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  output phase_t phase,
  output logic   dvalid
);
  // Divide-by-two phase; synchronous reset puts the next edge on capture.
  always_ff @(posedge clk) begin
    if (rst) phase <= PH_CAPTURE;
    else     phase <= (phase == PH_CAPTURE) ? PH_HOLD : PH_CAPTURE;
  end

  // Strobe: asynchronous clear, so it drops as soon as reset rises.
  always_ff @(posedge clk or posedge rst) begin
    if (rst) dvalid <= 1'b0;
    else     dvalid <= (phase == PH_HOLD);
  end
endmodule

// File: rtl/hrds_pipe.sv
`timescale 1ns/1ps
module hrds_pipe #(
  parameter int W     = 16,
  parameter int DEPTH = 6
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] a_in,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] a_q,
  output logic [W-1:0] b_q,
  output logic         ok_q
);
  logic [W-1:0]     a_st [DEPTH];
  logic [W-1:0]     b_st [DEPTH];
  logic [DEPTH-1:0] ok_st;

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    logic [W-1:0] a_src, b_src;
    logic         ok_src;
    if (i == 0) begin : g_head
      assign a_src  = a_in;
      assign b_src  = b_in;
      assign ok_src = 1'b1;
    end else begin : g_body
      assign a_src  = a_st[i-1];
      assign b_src  = b_st[i-1];
      assign ok_src = ok_st[i-1];
    end

    // Data words hold through reset; only the tag is cleared.
    always_ff @(posedge clk) begin
      if (adv) begin
        a_st[i] <= a_src;
        b_st[i] <= b_src;
      end
    end

    always_ff @(posedge clk) begin
      if (rst)      ok_st[i] <= 1'b0;
      else if (adv) ok_st[i] <= ok_src;
    end
  end

  assign a_q  = a_st[DEPTH-1];
  assign b_q  = b_st[DEPTH-1];
  assign ok_q = ok_st[DEPTH-1];
endmodule

// File: rtl/hrds_outreg.sv
`timescale 1ns/1ps
module hrds_outreg #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] a_d,
  input  logic [W-1:0] b_d,
  input  logic         ok_d,
  output logic [W-1:0] a_out,
  output logic [W-1:0] b_out,
  output logic         bad
);
  always_ff @(posedge clk) begin
    if (adv) begin
      a_out <= a_d;
      b_out <= b_d;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)      bad <= 1'b1;
    else if (adv) bad <= ~ok_d;
  end
endmodule

// File: rtl/halfrate_dual_seq.sv
`timescale 1ns/1ps
module halfrate_dual_seq
  import hrds_pkg::*;
#(
  parameter int WORD_W  = 16,
  parameter int LAT_CLK = 12
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] chan_a_in,
  input  logic [WORD_W-1:0] chan_b_in,
  output logic              dvalid,
  output logic [WORD_W-1:0] chan_a_out,
  output logic [WORD_W-1:0] chan_b_out,
  output logic              out_invalid
);
  // Stages between capture and output; the output register adds the last hop.
  localparam int STAGES = LAT_CLK / 2;

  phase_t            phase;
  logic              adv;
  logic [WORD_W-1:0] a_tail, b_tail;
  logic              ok_tail;

  hrds_phase u_phase (
    .clk    (clk),
    .rst    (rst),
    .phase  (phase),
    .dvalid (dvalid)
  );

  assign adv = (phase == PH_CAPTURE) && !rst;

  hrds_pipe #(.W(WORD_W), .DEPTH(STAGES)) u_pipe (
    .clk  (clk),
    .rst  (rst),
    .adv  (adv),
    .a_in (chan_a_in),
    .b_in (chan_b_in),
    .a_q  (a_tail),
    .b_q  (b_tail),
    .ok_q (ok_tail)
  );

  hrds_outreg #(.W(WORD_W)) u_out (
    .clk   (clk),
    .rst   (rst),
    .adv   (adv),
    .a_d   (a_tail),
    .b_d   (b_tail),
    .ok_d  (ok_tail),
    .a_out (chan_a_out),
    .b_out (chan_b_out),
    .bad   (out_invalid)
  );
endmodule

// File: rtl/hrds_checker.sv
`timescale 1ns/1ps
module hrds_checker #(
  parameter int WORD_W = 16
) (
  input logic              clk,
  input logic              rst,
  input logic              dvalid,
  input logic [WORD_W-1:0] chan_a_out,
  input logic [WORD_W-1:0] chan_b_out,
  input logic              out_invalid
);
  // Counts the first edges so that no $past reaches before time zero.
  logic [1:0] arm = 2'd0;
  always_ff @(posedge clk) if (arm != 2'd3) arm <= arm + 2'd1;

  p_strobe_low_r1: assert property (@(posedge clk) disable iff (arm != 2'd3)
    rst |-> !dvalid);

  p_hold_words_r2: assert property (@(posedge clk) disable iff (arm != 2'd3)
    $past(rst) |-> ($stable(chan_a_out) && $stable(chan_b_out)));

  p_toggle_r3: assert property (@(posedge clk) disable iff (rst || arm != 2'd3)
    (!$past(rst) && !$past(rst, 2)) |-> (dvalid != $past(dvalid)));

  p_change_on_fall_r6: assert property (@(posedge clk) disable iff (arm != 2'd3)
    (!$past(rst) && !($stable(chan_a_out) && $stable(chan_b_out))) |-> !dvalid);

  p_invalid_set_r7: assert property (@(posedge clk) disable iff (arm != 2'd3)
    $past(rst) |-> out_invalid);

  p_invalid_clear_r7: assert property (@(posedge clk) disable iff (arm != 2'd3)
    $fell(out_invalid) |-> !dvalid);
endmodule

bind halfrate_dual_seq hrds_checker #(.WORD_W(WORD_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .dvalid      (dvalid),
  .chan_a_out  (chan_a_out),
  .chan_b_out  (chan_b_out),
  .out_invalid (out_invalid)
);

// File: tb/halfrate_dual_seq_tb.sv
`timescale 1ns/1ps
module halfrate_dual_seq_tb;
  localparam int W   = 16;
  localparam int LAT = 12;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [W-1:0] chan_a_in = '0;
  logic [W-1:0] chan_b_in = '0;
  logic         dvalid;
  logic [W-1:0] chan_a_out, chan_b_out;
  logic         out_invalid;

  int n_chk  = 0;
  int n_fail = 0;

  always #2 clk = ~clk;  // 250 MHz

  halfrate_dual_seq #(.WORD_W(W), .LAT_CLK(LAT)) u_dut (
    .clk         (clk),
    .rst         (rst),
    .chan_a_in   (chan_a_in),
    .chan_b_in   (chan_b_in),
    .dvalid      (dvalid),
    .chan_a_out  (chan_a_out),
    .chan_b_out  (chan_b_out),
    .out_invalid (out_invalid)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Words presented at edge Ek; even edges carry junk that must never appear (R4).
  function automatic logic [W-1:0] pat_a(input int mode, input int k);
    logic [W-1:0] kk = W'(k);
    if (k % 2 == 0) return 16'hBAD0 ^ kk;
    case (mode)
      0:       return W'(k * 37 + 5);
      1:       return kk[1] ? 16'hFFFF : 16'h0000;
      default: return 16'h0001 << ((k / 2) % W);
    endcase
  endfunction

  function automatic logic [W-1:0] pat_b(input int mode, input int k);
    logic [W-1:0] a = pat_a(mode, k);
    return {a[7:0], a[15:8]} ^ 16'h3C3C;
  endfunction

  task automatic t_reset_state();
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(dvalid == 1'b0, "R1 strobe low in reset", 32'(dvalid), 32'd0);
    chk(out_invalid == 1'b1, "R7 invalid in reset", 32'(out_invalid), 32'd1);
  endtask

  // Precondition: at a negedge with rst high.
  task automatic t_stream(input int mode, input int n);
    rst = 1'b0;
    for (int k = 1; k <= n; k++) begin
      chan_a_in = pat_a(mode, k);
      chan_b_in = pat_b(mode, k);
      @(posedge clk);
      @(negedge clk);
      chk(dvalid == (k % 2 == 0), "R3 strobe phase", 32'(dvalid), 32'(k % 2 == 0));
      chk(out_invalid == (k <= LAT), "R7 invalid window", 32'(out_invalid), 32'(k <= LAT));
      if (k > LAT) begin
        int src;
        src = (k % 2 == 1) ? k - LAT : k - LAT - 1;
        if (k % 2 == 1) begin
          chk(chan_a_out == pat_a(mode, src), "R5 R4 channel A latency", 32'(chan_a_out), 32'(pat_a(mode, src)));
          chk(chan_b_out == pat_b(mode, src), "R8 channel B path", 32'(chan_b_out), 32'(pat_b(mode, src)));
        end else begin
          chk(chan_a_out == pat_a(mode, src), "R6 A held over strobe rise", 32'(chan_a_out), 32'(pat_a(mode, src)));
          chk(chan_b_out == pat_b(mode, src), "R6 B held over strobe rise", 32'(chan_b_out), 32'(pat_b(mode, src)));
        end
      end
    end
  endtask

  // Precondition: at a negedge after an even edge (strobe high).
  task automatic t_midrun_reset();
    logic [W-1:0] held_a, held_b;
    held_a = chan_a_out;
    held_b = chan_b_out;
    chk(dvalid == 1'b1, "R3 strobe high before reset", 32'(dvalid), 32'd1);
    #1 rst = 1'b1;
    #0.5;
    chk(dvalid == 1'b0, "R1 immediate clear", 32'(dvalid), 32'd0);
    for (int i = 0; i < 5; i++) begin
      chan_a_in = 16'h1234 + W'(i);
      chan_b_in = 16'h4321 - W'(i);
      @(negedge clk);
      chk(chan_a_out == held_a, "R2 A held in reset", 32'(chan_a_out), 32'(held_a));
      chk(chan_b_out == held_b, "R2 B held in reset", 32'(chan_b_out), 32'(held_b));
      chk(dvalid == 1'b0, "R1 strobe stays low", 32'(dvalid), 32'd0);
      chk(out_invalid == 1'b1, "R7 invalid set by reset", 32'(out_invalid), 32'd1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog expired actual=hung expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    t_reset_state();
    t_stream(0, 40);
    t_midrun_reset();
    t_stream(1, 40);
    t_midrun_reset();
    t_stream(2, 40);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule